// File: doc/BRIEF.md
# Pad Pull Configuration Strobe Sequencer

This block holds the pull configuration (none, pull-down or pull-up) of a set of pads and lets software change it only through a timed two-step handshake. Software first writes a 2-bit pull code into a shared control register. After a setup interval it raises the bits of the pins it wants to change in one or more strobe bank registers. After a hold interval it drops those bits again. A pin takes the control code into its pull state only when its strobe bit falls after both intervals were respected.

The pull state drives the pad pull resistors directly and cannot be read back through the register port. Each strobe bank register covers 32 pins, so several pins, in one bank or across banks, can be set to the same code in one pass. Both intervals are counted in clock cycles and are parameters, 150 by default.

Top module: `pud_strobe_seq`

## Requirements
- R1: After reset every pin's pull state is 0 (none), the strobe banks read as all zero and the control register holds code 0 with no setup interval satisfied.
- R2: A write to the control address (0x94) stores bits [1:0] of the data as the pending code and ignores bits [31:2]; code 0 means none, 1 pull-down, 2 pull-up; pin i's state appears on pull_state[2i+1:2i].
- R3: A pending code of 3 is stored into a pin as 0 (none), so pull_state never shows 3 for any pin.
- R4: A pin latches only if its strobe bit was raised at least SETUP_CYC clock edges after the most recent control write; every control write restarts this interval, and with no control write since reset no pin latches.
- R5: A pin latches only if its strobe bit is cleared at least HOLD_CYC clock edges after the edge that raised it; writing 1 over a bit that is already 1 does not restart the hold interval.
- R6: The new state is visible in the cycle after the write that clears the strobe bit; only pins whose strobe bit falls change, all others keep their state.
- R7: Strobe bank b sits at address 0x98 + 4*b and its bit j strobes pin 32*b + j; any number of pins across banks can be strobed in one pass and all take the same code.
- R8: A control write while a pin's strobe bit is high cancels that pin's pending update, even if the hold interval is later met.
- R9: Writes to any other address, and control writes themselves, leave every pin's pull state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | AW | Register byte address |
| wr_data | input | 32 | Register write data |
| pull_state | output | 2*NUM_PINS | Pull code per pin, pin i at bits [2i+1:2i] |

## Verification
The handshake is driven with every control code, including the reserved value and data with junk above bit 1, and sweeps all 64 pins over several rounds so each pin sees each legal code and the two banks are shown to be independent. Setup and hold are tried exactly at the limit and one cycle short; because the second bank is raised one cycle after the first, a single pass with a 149-cycle setup separates a bank that latches from one that does not. Further patterns tell apart a held strobe cancelled by a control rewrite, a strobe with no control write since reset, a rewrite of a set bit that must not restart the hold count, and writes to unmapped addresses.

// File: rtl/pud_strobe_seq.sv
module pud_strobe_seq #(
  parameter int NUM_PINS    = 64,
  parameter int SETUP_CYC   = 150,
  parameter int HOLD_CYC    = 150,
  parameter int AW          = 8,
  parameter int CTRL_ADDR   = 'h94,
  parameter int STROBE_ADDR = 'h98
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [31:0]           wr_data,
  output logic [2*NUM_PINS-1:0] pull_state
);
  localparam int NB  = (NUM_PINS + 31) / 32;
  localparam int TOT = NB * 32;
  localparam int SW  = $clog2(SETUP_CYC + 1);
  localparam int HW  = $clog2(HOLD_CYC + 1);
  localparam logic [TOT-1:0] VALID = {TOT{1'b1}} >> (TOT - NUM_PINS);

  logic [1:0]     ctrl_q;
  logic [SW-1:0]  setup_cnt;
  logic [TOT-1:0] strobe_q, strobe_d;
  logic           ctrl_wr, setup_done;
  logic [1:0]     new_code;

  assign ctrl_wr    = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign setup_done = (setup_cnt == SW'(SETUP_CYC));
  assign new_code   = (ctrl_q == 2'd3) ? 2'd0 : ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      setup_cnt <= '0;
    end else if (ctrl_wr) begin
      ctrl_q    <= wr_data[1:0];
      setup_cnt <= SW'(1);
    end else if (setup_cnt != '0 && !setup_done) begin
      setup_cnt <= setup_cnt + SW'(1);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = wr_en && (wr_addr == AW'(STROBE_ADDR + 4 * b));
    assign strobe_d[b*32 +: 32] = bank_hit ? wr_data : strobe_q[b*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe_d & VALID;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic          armed;
    logic [HW-1:0] hcnt;
    logic [1:0]    st;
    logic          rise, fall;

    assign rise = strobe_d[i] & ~strobe_q[i];
    assign fall = ~strobe_d[i] & strobe_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed <= 1'b0;
        hcnt  <= '0;
        st    <= 2'd0;
      end else if (rise) begin
        armed <= setup_done;
        hcnt  <= HW'(1);
      end else if (fall) begin
        if (armed && hcnt == HW'(HOLD_CYC)) st <= new_code;
        armed <= 1'b0;
        hcnt  <= '0;
      end else if (strobe_q[i]) begin
        if (ctrl_wr) armed <= 1'b0;
        if (hcnt != HW'(HOLD_CYC)) hcnt <= hcnt + HW'(1);
      end
    end

    assign pull_state[2*i +: 2] = st;
  end
endmodule

module pud_strobe_seq_chk #(
  parameter int NUM_PINS    = 64,
  parameter int AW          = 8,
  parameter int CTRL_ADDR   = 'h94,
  parameter int STROBE_ADDR = 'h98
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [2*NUM_PINS-1:0] pull_state
);
  localparam int NB = (NUM_PINS + 31) / 32;

  logic ctrl_hit, strobe_hit, seen_ctrl;
  assign ctrl_hit   = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign strobe_hit = wr_en && (wr_addr >= AW'(STROBE_ADDR)) &&
                      (wr_addr < AW'(STROBE_ADDR + 4 * NB)) && (wr_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)        seen_ctrl <= 1'b0;
    else if (ctrl_hit) seen_ctrl <= 1'b1;
  end

  a_r1_reset_none: assert property (@(posedge clk) !rst_n |=> (pull_state == '0));

  a_r9_ctrl_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> $stable(pull_state));

  a_r6_change_needs_strobe_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_state) |-> $past(strobe_hit));

  a_r4_change_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_state) |-> seen_ctrl);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_legal
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      pull_state[2*i +: 2] != 2'b11);
  end
endmodule

bind pud_strobe_seq pud_strobe_seq_chk #(
  .NUM_PINS(NUM_PINS), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .STROBE_ADDR(STROBE_ADDR)
) u_chk (.*);

// File: tb/pud_strobe_seq_tb.sv
`timescale 1ns/1ps
module pud_strobe_seq_tb;
  localparam int NP = 64;
  localparam int SU = 150;
  localparam int HO = 150;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [2*NP-1:0] pull_state;
  logic [2*NP-1:0] exp_vec = '0;
  int checks = 0;
  int errors = 0;

  pud_strobe_seq u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                        .wr_data(wr_data), .pull_state(pull_state));

  always #4 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] map_code(input logic [31:0] c);
    return (c[1:0] == 2'd3) ? 2'd0 : c[1:0];
  endfunction

  task automatic model(input logic [31:0] c, input logic [31:0] m, input int base,
                       input int sg, input int hg);
    if (sg >= SU && hg >= HO)
      for (int j = 0; j < 32; j++)
        if (m[j]) exp_vec[2*(base+j) +: 2] = map_code(c);
  endtask

  // bank 0 raised sg edges after control write, bank 1 one edge later; both held hg edges
  task automatic strobe(input logic [31:0] c, input logic [31:0] m0, input logic [31:0] m1,
                        input int sg, input int hg);
    wr(8'h94, c);
    idle(sg - 1);
    wr(8'h98, m0);
    wr(8'h9C, m1);
    idle(hg - 2);
    wr(8'h98, 32'h0);
    wr(8'h9C, 32'h0);
    model(c, m0, 0, sg, hg);
    model(c, m1, 32, sg + 1, hg);
  endtask

  task automatic check(input string tag);
    checks++;
    if (pull_state !== exp_vec) begin
      errors++;
      $display("FAIL %s: pull_state actual=%h expected=%h", tag, pull_state, exp_vec);
    end
  endtask

  initial begin
    #(8ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired (R1..R9 run incomplete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset state all none");

    // R4: strobe with no control write since reset
    wr(8'h98, 32'h1); idle(SU + 10); wr(8'h98, 32'h0);
    check("R4 no control write since reset");

    // R2, R7: pull-up at exact boundaries over both banks
    strobe(32'h2, 32'h0000_00FF, 32'h0000_000F, SU, HO);
    check("R2 R7 pull-up both banks at limits");
    strobe(32'hABCD_0001, 32'h0000_0FF0, 32'h0, SU, HO);
    check("R2 pull-down upper data bits ignored");
    // R3: reserved code
    strobe(32'h3, 32'h0000_0003, 32'h0, SU, HO);
    check("R3 reserved code stored as none");
    strobe(32'hFFFF_FFFC, 32'h0000_0040, 32'h0, SU, HO);
    check("R2 code none with junk high bits");

    // R4: bank0 setup 149 fails, bank1 setup 150 latches
    strobe(32'h1, 32'h0010_0000, 32'h0000_0100, SU - 1, HO);
    check("R4 setup one short vs exact");
    // R5: hold one short
    strobe(32'h2, 32'h0020_0000, 32'h0000_0200, SU, HO - 1);
    check("R5 hold one short");

    // R8: control rewrite while strobe held
    wr(8'h94, 32'h2); idle(SU - 1);
    wr(8'h98, 32'h0040_0000); idle(10);
    wr(8'h94, 32'h2); idle(SU);
    wr(8'h98, 32'h0);
    check("R8 control write during hold cancels");

    // R9: unmapped writes and control writes
    wr(8'hA0, 32'hFFFF_FFFF); wr(8'h90, 32'hFFFF_FFFF); wr(8'h95, 32'hFFFF_FFFF);
    wr(8'h94, 32'h1); idle(2);
    check("R9 unmapped and control writes no effect");

    // R5: set over set must not restart hold
    wr(8'h94, 32'h1); idle(SU - 1);
    wr(8'h98, 32'h0080_0000); idle(100);
    wr(8'h98, 32'h0080_0000); idle(49);
    wr(8'h98, 32'h0);
    exp_vec[2*23 +: 2] = 2'd1;
    check("R5 R9 rewrite of set bit keeps hold count");

    // R6 R7: near-exhaustive sweep, every pin gets every legal code
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 3; c++) begin
        logic [31:0] m0, m1;
        m0 = '0; m1 = '0;
        for (int p = 0; p < NP; p++)
          if ((p + k) % 3 == c) begin
            if (p < 32) m0[p] = 1'b1; else m1[p-32] = 1'b1;
          end
        strobe(32'(c), m0, m1, SU + k, HO + c);
        check($sformatf("R6 R7 sweep round %0d code %0d", k, c));
      end
    end

    // R6: single pin change leaves neighbours intact
    strobe(32'h2, 32'h0, 32'h8000_0000, SU, HO);
    check("R6 only strobed pin changes");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule